// File: doc/BRIEF.md
# Byte-Fed Group CRC-16 Checker

The block checks data groups that arrive one byte at a time. Each group is a run of data bytes followed by a 16-bit check word, sent high byte first. Every byte that arrives with its valid strobe goes through a 16-bit CRC register in one clock. The pass output is high whenever that register holds all zeros. A group that arrives intact therefore leaves a zero residue once its check word has gone in.

The register keeps its value between transfers. A group of any length can be split into several bursts with idle cycles between them. The only way to clear the register during operation is a level-held clear input, which software raises and must lower again before sending more data. After an intact group the register is already zero, so the next group can follow without a clear.

The polynomial is x^16+x^12+x^5+1 (0x1021). The initial value is 0x0000, and the bits of each byte enter most significant bit first.

Top module: `crc_group_check`

## Requirements
- R1: After the asynchronous reset rst_ni, crc_o is 0x0000 and pass_o is 1.
- R2: A byte on byte_i with byte_valid_i high and clear_i low updates crc_o on the next clock edge. The new value is the CRC of that byte over the old value: polynomial 0x1021, bit 7 first, no reflection, no final XOR.
- R3: In a cycle with byte_valid_i low and clear_i low, crc_o keeps its value.
- R4: pass_o is 1 exactly when all 16 bits of crc_o are 0, and it follows crc_o in the same cycle.
- R5: While clear_i is high, the register is loaded with 0x0000 on every edge, and bytes strobed during that time are ignored. The clear stays in force until clear_i is lowered.
- R6: Data bytes followed by their own check word, high byte first, leave crc_o at 0x0000 and pass_o at 1.
- R7: A group split into bursts with any number of idle cycles between bytes gives the same crc_o as the same bytes sent back to back.
- R8: After an intact group, a following intact group also ends with pass_o at 1, with no clear in between.
- R9: A group with any single bit flipped in its data ends with pass_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Data or check-word byte |
| byte_valid_i | input | 1 | byte_i is absorbed on this edge |
| clear_i | input | 1 | Level-held clear of the CRC register |
| pass_o | output | 1 | CRC register is all zeros |
| crc_o | output | 16 | Current CRC register value |

## Verification
All 256 byte values are fed one at a time from a cleared register. This exposes any wrong tap, bit order or feedback term in the update. Messages of growing length, each with its check word appended and none cleared in between, show that the residue goes to zero and that back-to-back groups need no clear. The same bytes are sent again with irregular idle gaps, which shows that timing has no effect on the result. Finally, single-bit corruptions and bytes strobed under a held clear separate a real check from a stuck pass flag and from a clear that leaks data.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'h0000;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned CRC_W  = crc_pkg::CRC_W,
  parameter int unsigned BYTE_W = crc_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY = crc_pkg::CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned TOP = CRC_W - 1;

  // all BYTE_W serial shifts unrolled into one combinational step
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_i;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[TOP] ^ data_i[i];
      c  = {c[TOP-1:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned CRC_W = crc_pkg::CRC_W,
  parameter logic [CRC_W-1:0] INIT = crc_pkg::CRC_INIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] crc_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q_o <= INIT;
    else if (clear_i) crc_q_o <= INIT;
    else if (load_i)  crc_q_o <= next_i;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i) |=> $stable(crc_q_o)); // R3
  AST_CLEAR_LOADS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_q_o == INIT)); // R5
endmodule

// File: rtl/crc_group_check.sv
module crc_group_check #(
  parameter int unsigned CRC_W  = crc_pkg::CRC_W,
  parameter int unsigned BYTE_W = crc_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY = crc_pkg::CRC_POLY,
  parameter logic [CRC_W-1:0] INIT = crc_pkg::CRC_INIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              clear_i,
  output logic              pass_o,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  crc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .data_i(byte_i),
    .crc_o (crc_next)
  );

  crc_state_reg #(.CRC_W(CRC_W), .INIT(INIT)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .load_i (byte_valid_i),
    .next_i (crc_next),
    .crc_q_o(crc_q)
  );

  assign crc_o  = crc_q;
  assign pass_o = ~|crc_q;

  AST_CLEAR_GIVES_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> pass_o); // R4
  AST_ZERO_BYTE_KEEPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !clear_i && pass_o && byte_i == '0) |=> pass_o); // R2
  AST_NONZERO_BYTE_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !clear_i && pass_o && byte_i != '0) |=> !pass_o); // R9
endmodule

// File: tb/sim_crc_group_check.sv
module sim_crc_group_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        valid = 1'b0;
  logic        clear = 1'b0;
  logic        pass;
  logic [15:0] crc;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  crc_group_check u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_valid_i(valid),
    .clear_i(clear), .pass_o(pass), .crc_o(crc)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] msg_byte(input int m, input int k);
    return 8'((m * 37 + k * 101 + (k * k) * 13) & 8'hff);
  endfunction

  task automatic cmp(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_d = b;
    valid  = 1'b1;
    @(negedge clk);
    valid  = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] model;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    cmp(crc, 16'h0000, "R1 reset crc");
    cmp({15'd0, pass}, 16'd1, "R1 reset pass");
    rst_n = 1'b1;

    // R2/R4: every byte value from a cleared register
    for (int b = 0; b < 256; b++) begin
      pulse_clear();
      send(8'(b));
      model = ref_crc(16'h0000, 8'(b));
      cmp(crc, model, "R2 single byte");
      cmp({15'd0, pass}, {15'd0, model == 16'h0000}, "R4 pass tracks crc");
    end

    // R3: idle cycles keep the value
    held = crc;
    repeat (6) @(negedge clk);
    cmp(crc, held, "R3 idle hold");

    // R5: bytes under a held clear are ignored
    @(negedge clk);
    clear = 1'b1;
    for (int k = 0; k < 4; k++) begin
      byte_d = 8'hA5 + 8'(k);
      valid = 1'b1;
      @(negedge clk);
      cmp(crc, 16'h0000, "R5 clear ignores bytes");
    end
    valid = 1'b0;
    clear = 1'b0;
    cmp({15'd0, pass}, 16'd1, "R5 pass under clear");

    // R6/R8: back-to-back intact groups, no clear between
    for (int m = 1; m <= 12; m++) begin
      model = 16'h0000;
      for (int k = 0; k < m; k++) begin
        send(msg_byte(m, k));
        model = ref_crc(model, msg_byte(m, k));
      end
      cmp(crc, model, "R2 group running crc");
      send(model[15:8]);
      send(model[7:0]);
      cmp(crc, 16'h0000, "R6 zero residue");
      cmp({15'd0, pass}, 16'd1, m > 1 ? "R8 next group passes" : "R6 pass");
    end

    // R7: split transfer with irregular gaps
    model = 16'h0000;
    for (int k = 0; k < 20; k++) begin
      send(msg_byte(7, k));
      model = ref_crc(model, msg_byte(7, k));
      repeat ((k * 5) % 7) @(negedge clk);
    end
    cmp(crc, model, "R7 split equals contiguous");
    send(model[15:8]);
    repeat (9) @(negedge clk);
    send(model[7:0]);
    cmp({15'd0, pass}, 16'd1, "R7 split group passes");

    // R9: single-bit corruption
    for (int bit_pos = 0; bit_pos < 16; bit_pos++) begin
      model = 16'h0000;
      for (int k = 0; k < 6; k++) model = ref_crc(model, msg_byte(3, k));
      pulse_clear();
      for (int k = 0; k < 6; k++) begin
        logic [7:0] b;
        b = msg_byte(3, k);
        if (k == bit_pos % 6) b = b ^ (8'h01 << (bit_pos % 8));
        send(b);
      end
      send(model[15:8]);
      send(model[7:0]);
      cmp({15'd0, pass}, 16'd0, "R9 corrupted group fails");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule